// File: doc/BRIEF.md
# I2C Register Target with Segmented Pointer Walk

This block is an I2C target (device side) that lets a bus controller read and write a small external register file. It watches the SCL and SDA lines, oversampled in the system clock domain, and detects START and STOP conditions. It compares the first byte of each transfer against a fixed 7-bit device address and uses the direction bit to choose a write or a read. In a write, the first byte after the address loads a register pointer and every later byte is data for the pointed-to register. In a read, the block shifts out register contents starting at the pointer.

After each data byte the pointer moves to the next address, but the address space is not contiguous. A low segment runs 00h to 03h and then skips to 10h through 18h. Where the pointer goes after 18h depends on a FIFO-enable input. Two small side segments, 30h to 32h and 60h to 62h, each wrap onto their own first address. A pointer outside every segment does not move, reads as zero and accepts no writes.

The register file sits outside the block and is reached through a plain combinational port. The block presents an address and write data with a one-cycle write strobe. The file returns the read data and a flag that says whether the addressed register accepts writes. SDA is open-drain: the block only ever pulls the line low.

Top module: `i2c_segreg_target`

## Requirements
- R1: A transfer whose address byte carries device address 0Ch in bits 7:1 is acknowledged (SDA pulled low in the ninth clock). Any other address is not acknowledged, and the target leaves SDA and the register port alone until the next START.
- R2: Address bit 0 selects the direction: 0 gives a write, in which the byte after the address loads the pointer; 1 gives a read, in which data is returned from the pointer.
- R3: In a write, every byte after the address is acknowledged. Each data byte is offered to the register at the pointer with a single-cycle write strobe, and the pointer then advances.
- R4: The pointer steps 00h, 01h, 02h, 03h, then jumps to 10h, and then steps by one up to 18h.
- R5: After 18h the pointer goes to 00h when fifo_en is 0 and to 11h when fifo_en is 1.
- R6: The pointer wraps from 32h to 30h and from 62h to 60h.
- R7: A data byte aimed at a register whose reg_writable flag is 0 is acknowledged but not written, and the pointer still advances.
- R8: In a read, a controller ACK makes the target send the byte at the next pointer value. A controller NACK makes the target release SDA until STOP or START.
- R9: The pointer keeps its value across transfers, so a read without a pointer phase starts where the previous transfer left the pointer.
- R10: A pointer outside 00h–03h, 10h–18h, 30h–32h and 60h–62h does not advance, reads back as 00h, and data bytes sent to it are not written.
- R11: After reset, SDA is released, no write strobe is active and the pointer is 00h.
- R12: The target changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| fifo_en | input | 1 | Selects the wrap target after 18h (0: 00h, 1: 11h) |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at reg_addr |
| reg_writable | input | 1 | 1 when the register at reg_addr accepts writes |

## Verification
The bench aims at the places where the pointer leaves plain counting. It checks the jump from 03h to 10h, both exits from 18h under each fifo_en value, and the wraps at 32h and 62h. A wrong step function shows up there as data landing in 04h, 19h or 33h, or as a read returning the wrong register. It writes through a read-only register and checks that the register keeps its value while the next register still receives the following byte; a design that stalls the pointer on a dropped byte would write that byte one address too low. It also parks the pointer at an unmapped address, where a design that kept counting or forwarded file data would return non-zero bytes or corrupt memory. It sends a foreign device address and checks that the target stays silent and writes nothing. It reads with no pointer phase to confirm the pointer carries over from the previous transfer, and checks after a NACK that SDA is released rather than driven with the next byte.

// File: rtl/i2c_segreg_pkg.sv
package i2c_segreg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_PTR,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        bus_st_e             st;
        byte_kind_e          kind;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   tx;
        logic [BYTE_W-1:0]   ptr;
        logic                ack;
        logic                rw;
        logic                mack;
    } ctl_s;

endpackage

// File: rtl/i2c_segreg_sync.sv
module i2c_segreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= scl_in;
                    sda_pipe_q <= sda_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
                    sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_segreg_ring.sv
module i2c_segreg_ring #(
    parameter logic [7:0] FIRST = 8'h30,
    parameter logic [7:0] LAST  = 8'h32
) (
    input  logic [7:0] cur,
    output logic       hit,
    output logic [7:0] nxt
);
    localparam logic [7:0] SPAN = LAST - FIRST;

    logic [7:0] offset;

    assign offset = cur - FIRST;
    assign hit    = (offset <= SPAN);
    assign nxt    = (cur == LAST) ? FIRST : cur + 8'd1;

endmodule

// File: rtl/i2c_segreg_step.sv
module i2c_segreg_step #(
    parameter logic [7:0]          A_FIRST   = 8'h00,
    parameter logic [7:0]          A_LAST    = 8'h03,
    parameter logic [7:0]          B_FIRST   = 8'h10,
    parameter logic [7:0]          B_LAST    = 8'h18,
    parameter logic [7:0]          B_REENTRY = 8'h11,
    parameter int                  NRING     = 2,
    parameter logic [NRING*8-1:0]  RING_LO   = {8'h60, 8'h30},
    parameter logic [NRING*8-1:0]  RING_HI   = {8'h62, 8'h32}
) (
    input  logic [7:0] cur,
    input  logic       fifo_en,
    output logic       valid,
    output logic [7:0] nxt
);
    localparam logic [7:0] A_SPAN = A_LAST - A_FIRST;
    localparam logic [7:0] B_SPAN = B_LAST - B_FIRST;

    logic [NRING-1:0] ring_hit;
    logic [7:0]       ring_nxt [NRING];
    logic [7:0]       a_off;
    logic [7:0]       b_off;
    logic             in_a;
    logic             in_b;

    genvar gi;
    generate
        for (gi = 0; gi < NRING; gi++) begin : g_ring
            i2c_segreg_ring #(
                .FIRST (RING_LO[gi*8 +: 8]),
                .LAST  (RING_HI[gi*8 +: 8])
            ) ring_i (
                .cur (cur),
                .hit (ring_hit[gi]),
                .nxt (ring_nxt[gi])
            );
        end
    endgenerate

    assign a_off = cur - A_FIRST;
    assign b_off = cur - B_FIRST;
    assign in_a  = (a_off <= A_SPAN);
    assign in_b  = (b_off <= B_SPAN);

    always_comb begin
        valid = 1'b0;
        nxt   = cur;
        if (in_a) begin
            valid = 1'b1;
            nxt   = (cur == A_LAST) ? B_FIRST : cur + 8'd1;
        end else if (in_b) begin
            valid = 1'b1;
            if (cur == B_LAST) begin
                nxt = fifo_en ? B_REENTRY : A_FIRST;
            end else begin
                nxt = cur + 8'd1;
            end
        end else begin
            for (int i = 0; i < NRING; i++) begin
                if (ring_hit[i]) begin
                    valid = 1'b1;
                    nxt   = ring_nxt[i];
                end
            end
        end
    end

endmodule

// File: rtl/i2c_segreg_target.sv
module i2c_segreg_target
    import i2c_segreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h0C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       fifo_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    input  logic       reg_writable
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_valid;
    logic [7:0] ptr_nxt;
    logic [7:0] rx_byte;
    logic [7:0] rd_byte;
    logic we_d;

    ctl_s q, d;

    i2c_segreg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_segreg_step step_i (
        .cur     (q.ptr),
        .fifo_en (fifo_en),
        .valid   (ptr_valid),
        .nxt     (ptr_nxt)
    );

    assign rx_byte = {q.sh[6:0], sda_s};
    assign rd_byte = ptr_valid ? reg_rdata : 8'h00;

    always_comb begin
        d    = q;
        we_d = 1'b0;
        if (start_det) begin
            d.st     = ST_RX;
            d.kind   = K_DEV;
            d.bitcnt = '0;
            d.ack    = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.bitcnt = '0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && (q.bitcnt < FULL_CNT)) begin
                        d.sh     = rx_byte;
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == LAST_BIT) begin
                            case (q.kind)
                                K_DEV: begin
                                    d.ack = (rx_byte[7:1] == DEV_ADDR);
                                    d.rw  = rx_byte[0];
                                end
                                K_PTR: begin
                                    d.ack = 1'b1;
                                    d.ptr = rx_byte;
                                end
                                K_DATA: begin
                                    d.ack = 1'b1;
                                    we_d  = ptr_valid & reg_writable;
                                    d.ptr = ptr_nxt;
                                end
                                default: d.ack = 1'b0;
                            endcase
                        end
                    end else if (scl_fall && (q.bitcnt == FULL_CNT)) begin
                        d.bitcnt = '0;
                        d.st     = q.ack ? ST_ACK : ST_IDLE;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if ((q.kind == K_DEV) && q.rw) begin
                            d.st  = ST_TX;
                            d.tx  = rd_byte;
                            d.ptr = ptr_nxt;
                        end else begin
                            d.st   = ST_RX;
                            d.kind = (q.kind == K_DEV) ? K_PTR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == FULL_CNT) begin
                            d.st     = ST_MACK;
                            d.bitcnt = '0;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.tx  = rd_byte;
                            d.ptr = ptr_nxt;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_DEV, bitcnt: '0, sh: '0, tx: '0,
                   ptr: '0, ack: 1'b0, rw: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = (q.st == ST_ACK) | ((q.st == ST_TX) & ~q.tx[7]);
    assign reg_addr  = q.ptr;
    assign reg_wdata = rx_byte;
    assign reg_we    = we_d;

endmodule

// File: rtl/i2c_segreg_target_chk.sv
module i2c_segreg_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       fifo_en,
    input logic [7:0] reg_addr,
    input logic       reg_we
);
    // R3: one strobe per received data byte
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4: low segment skips the gap
    a_r4_low_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h03) |=> (reg_addr == 8'h10));

    // R5: exit from the top of the low segment
    a_r5_wrap_fifo_on: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h18 && fifo_en) |=> (reg_addr == 8'h11));

    a_r5_wrap_fifo_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h18 && !fifo_en) |=> (reg_addr == 8'h00));

    // R6: side segments wrap onto their own first address
    a_r6_ring_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h32) |=> (reg_addr == 8'h30));

    a_r6_ring_high: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h62) |=> (reg_addr == 8'h60));

    // R12: SDA drive changes only with SCL low
    a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

endmodule

bind i2c_segreg_target i2c_segreg_target_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .fifo_en  (fifo_en),
    .reg_addr (reg_addr),
    .reg_we   (reg_we)
);

// File: tb/i2c_segreg_target_tb_top.sv
module i2c_segreg_target_tb_top;

    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h18;
    localparam logic [7:0] AR = 8'h19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       fifo_en = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_writable;
    logic [7:0] mem [256];
    logic       seen_oe;
    logic       seen_we;
    int         errors = 0;
    int         checks = 0;

    always #4 clk = ~clk;

    assign sda_line     = ~(m_sda_low | sda_oe);
    assign reg_rdata    = mem[reg_addr];
    assign reg_writable = !(reg_addr == 8'h00 || reg_addr == 8'h10);

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (sda_oe) seen_oe <= 1'b1;
        if (reg_we) seen_we <= 1'b1;
    end

    i2c_segreg_target dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .fifo_en      (fifo_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_rdata    (reg_rdata),
        .reg_writable (reg_writable)
    );

    task automatic tk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tk(Q);
        m_scl = 1'b1;     tk(Q);
        m_sda_low = 1'b1; tk(Q);
        m_scl = 1'b0;     tk(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tk(Q);
        m_scl = 1'b1;     tk(Q);
        m_sda_low = 1'b0; tk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; tk(Q);
            m_scl = 1'b1;      tk(2*Q);
            m_scl = 1'b0;      tk(Q);
        end
        m_sda_low = 1'b0; tk(Q);
        m_scl = 1'b1;     tk(Q);
        ack = !sda_line;  tk(Q);
        m_scl = 1'b0;     tk(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tk(Q);
            m_scl = 1'b1; tk(Q);
            b[i] = sda_line; tk(Q);
            m_scl = 1'b0;
        end
        tk(Q);
        m_sda_low = give_ack; tk(Q);
        m_scl = 1'b1;         tk(2*Q);
        m_scl = 1'b0;         tk(Q);
        m_sda_low = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        bit a;
        chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        chk(reg_we == 1'b0, "R11 no strobe", reg_we, 0);
        bus_start();
        send_byte(AR, a);
        chk(a, "R1 read address acked", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'hA5, "R11 pointer starts at 00h", b, 8'hA5);
        bus_stop();
    endtask

    task automatic t_write_ring_mid();
        bit a;
        int nack = 0;
        bus_start();
        send_byte(AW, a); if (!a) nack++;
        send_byte(8'h30, a); if (!a) nack++;
        send_byte(8'h11, a); if (!a) nack++;
        send_byte(8'h22, a); if (!a) nack++;
        send_byte(8'h33, a); if (!a) nack++;
        send_byte(8'h44, a); if (!a) nack++;
        bus_stop();
        chk(nack == 0, "R3 every write byte acked", nack, 0);
        chk(mem[8'h30] == 8'h44, "R6 32h wraps to 30h", mem[8'h30], 8'h44);
        chk(mem[8'h31] == 8'h22, "R3 auto increment", mem[8'h31], 8'h22);
        chk(mem[8'h32] == 8'h33, "R3 data at 32h", mem[8'h32], 8'h33);
    endtask

    task automatic t_write_low();
        bit a;
        int nack = 0;
        bus_start();
        send_byte(AW, a); if (!a) nack++;
        send_byte(8'h02, a); if (!a) nack++;
        send_byte(8'h51, a); if (!a) nack++;
        send_byte(8'h52, a); if (!a) nack++;
        send_byte(8'h53, a); if (!a) nack++;
        send_byte(8'h54, a); if (!a) nack++;
        bus_stop();
        chk(nack == 0, "R7 read-only byte still acked", nack, 0);
        chk(mem[8'h02] == 8'h51, "R2 write data at pointer", mem[8'h02], 8'h51);
        chk(mem[8'h03] == 8'h52, "R4 step to 03h", mem[8'h03], 8'h52);
        chk(mem[8'h04] == 8'hA1, "R4 04h skipped", mem[8'h04], 8'hA1);
        chk(mem[8'h10] == 8'hB5, "R7 read-only not written", mem[8'h10], 8'hB5);
        chk(mem[8'h11] == 8'h54, "R7 pointer advanced past drop", mem[8'h11], 8'h54);
    endtask

    task automatic t_read_fifo_off();
        logic [7:0] b0, b1, b2;
        bit a;
        fifo_en = 1'b0;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h17, a);
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        chk(b0 == 8'hB2, "R2 read at pointer 17h", b0, 8'hB2);
        chk(b1 == 8'hBD, "R8 ack gives next byte 18h", b1, 8'hBD);
        chk(b2 == 8'hA5, "R5 18h to 00h with fifo off", b2, 8'hA5);
        seen_oe = 1'b0;
        tk(2*Q);
        chk(seen_oe == 1'b0, "R8 SDA released after NACK", seen_oe, 0);
        bus_stop();
    endtask

    task automatic t_read_fifo_on();
        logic [7:0] b0, b1;
        bit a;
        fifo_en = 1'b1;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h18, a);
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        chk(b0 == 8'hBD, "R8 read at 18h", b0, 8'hBD);
        chk(b1 == 8'h54, "R5 18h to 11h with fifo on", b1, 8'h54);
    endtask

    task automatic t_persist();
        logic [7:0] b;
        bit a;
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk(b == 8'hB7, "R9 read resumes at 12h", b, 8'hB7);
    endtask

    task automatic t_ring_high();
        bit a;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h61, a);
        send_byte(8'h71, a);
        send_byte(8'h72, a);
        send_byte(8'h73, a);
        bus_stop();
        chk(mem[8'h62] == 8'h72, "R6 data at 62h", mem[8'h62], 8'h72);
        chk(mem[8'h60] == 8'h73, "R6 62h wraps to 60h", mem[8'h60], 8'h73);
        chk(mem[8'h63] == 8'hC6, "R6 63h untouched", mem[8'h63], 8'hC6);
    endtask

    task automatic t_unmapped();
        logic [7:0] b0, b1;
        bit a;
        int nack = 0;
        seen_we = 1'b0;
        bus_start();
        send_byte(AW, a); if (!a) nack++;
        send_byte(8'h40, a); if (!a) nack++;
        send_byte(8'h81, a); if (!a) nack++;
        send_byte(8'h82, a); if (!a) nack++;
        bus_stop();
        chk(nack == 0, "R10 unmapped bytes acked", nack, 0);
        chk(seen_we == 1'b0, "R10 no write strobe", seen_we, 0);
        chk(mem[8'h40] == 8'hE5, "R10 40h unchanged", mem[8'h40], 8'hE5);
        chk(mem[8'h41] == 8'hE4, "R10 41h unchanged", mem[8'h41], 8'hE4);
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        chk(b0 == 8'h00, "R10 unmapped reads 00h", b0, 0);
        chk(b1 == 8'h00, "R10 pointer held", b1, 0);
    endtask

    task automatic t_bad_address();
        bit a0, a1, a2;
        seen_oe = 1'b0;
        seen_we = 1'b0;
        bus_start();
        send_byte(8'h1A, a0);
        send_byte(8'h30, a1);
        send_byte(8'h99, a2);
        bus_stop();
        chk(!a0, "R1 foreign address not acked", a0, 0);
        chk(!a1 && !a2, "R1 later bytes ignored", {a1, a2}, 0);
        chk(seen_oe == 1'b0 && seen_we == 1'b0, "R1 bus left alone",
            {seen_oe, seen_we}, 0);
        chk(mem[8'h30] == 8'h44, "R1 30h unchanged", mem[8'h30], 8'h44);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        seen_oe = 1'b0;
        seen_we = 1'b0;
        tk(5);
        rst_n = 1'b1;
        tk(5);
        t_reset();
        t_write_ring_mid();
        t_write_low();
        t_read_fifo_off();
        t_read_fifo_on();
        t_persist();
        t_ring_high();
        t_unmapped();
        t_bad_address();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule